// File: doc/BRIEF.md
# Crosstalk Link Self-Test Generator and Checker

This block is a self-test pair for one point-to-point link of parallel wires between two network switches. The generating end drives a fixed series of link words. Each word pairs a single victim wire against all other wires, which act as aggressors. The words are built to provoke the worst coupling effects on the victim: delayed rising and falling edges, glitches in either direction, and edges that arrive too early. The victim position moves from wire 0 up to the last wire, one wire after each burst of eight words.

The receiving end rebuilds the same words in lockstep and compares them bit by bit with what it receives. Any difference raises a sticky error. The victim index and the step number of the first difference are kept for diagnosis. The link itself is outside the block: it is treated as a registered wire with `LINK_LAT` register stages, and faults may be injected on it. Software or a test controller pulses `start`. It then waits for `done` and reads `err`, `fail_vic` and `fail_step`.

Top module: `xt_link_bist`

## Requirements
- R1: After reset, `link_tx`, `busy`, `done`, `err`, `fail_vic` and `fail_step` are all zero.
- R2: A `start` pulse sampled at a clock edge while `busy` is low starts a test. The first word appears on `link_tx` after the following edge, and `busy` is high from the accepting edge onward.
- R3: Steps are numbered 1 to 8. For each step, the victim wire (index = current victim) and every other wire take these levels as (victim, others): 1:(0,0), 2:(1,1), 3:(0,0), 4:(0,1), 5:(1,0), 6:(0,1), 7:(1,1), 8:(1,0).
- R4: Victims run from 0 to LANES-1 in ascending order. Each victim gets steps 1 to 8 on consecutive cycles, giving 8*LANES back-to-back words. After the last word, `link_tx` returns to all zeros.
- R5: The checker compares the received word with the word the generator drove `LINK_LAT`+1 cycles earlier. A difference in any bit sets `err` at the next edge.
- R6: `err` stays set until the next accepted start. `fail_vic` and `fail_step` hold the victim and step (1..8) of the first mismatching word, and later mismatches do not change them.
- R7: `done` is high for exactly one cycle. It rises at the edge that registers the comparison of step 8 of victim LANES-1, which is edge 8*LANES+LINK_LAT+1 after the accepting edge.
- R8: `start` while `busy` is high has no effect. An accepted start clears `err`, `fail_vic`, `fail_step` and `done` at its edge.
- R9: `busy` falls in the same cycle in which `done` rises.
- R10: While no test word is due at the receiver, corrupted values on `link_rx` do not set `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Test start pulse |
| link_tx | output | LANES | Word driven onto the link (registered) |
| link_rx | input | LANES | Word received from the far end of the link |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| err | output | 1 | Sticky mismatch flag |
| fail_vic | output | $clog2(LANES) | Victim index of the first mismatch |
| fail_step | output | 4 | Step number (1..8) of the first mismatch |

## Verification
The end-of-test pulse and the sticky error can both fire at the same edge, when the very last word (step 8 of the highest victim) arrives corrupted. The bench injects a fault on that word only. It then requires `err` and `done` to rise together, with `fail_vic` equal to LANES-1 and `fail_step` equal to 8. A second coincidence is a `start` pulse that arrives in the middle of a run. The bench drives one and requires the timing of the word stream and of `done` to be identical to those of an undisturbed run.

// File: rtl/xt_pkg.sv
package xt_pkg;

  localparam int unsigned SEQ_LEN = 8;

  typedef logic [3:0] step_t;

  typedef struct packed {
    logic vic;
    logic agg;
  } lvl_t;

  // Victim and aggressor levels for each step of one victim burst.
  function automatic lvl_t step_levels(step_t s);
    lvl_t l;
    case (s)
      4'd2, 4'd7: l = '{vic: 1'b1, agg: 1'b1};
      4'd4, 4'd6: l = '{vic: 1'b0, agg: 1'b1};
      4'd5, 4'd8: l = '{vic: 1'b1, agg: 1'b0};
      default:    l = '{vic: 1'b0, agg: 1'b0};
    endcase
    return l;
  endfunction

endpackage

// File: rtl/xt_seq.sv
module xt_seq
  import xt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int VW    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output step_t         step,
  output logic [VW-1:0] vic,
  output logic          last
);

  localparam step_t   STEP_END = step_t'(SEQ_LEN);
  localparam [VW-1:0] VIC_END  = VW'(LANES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      vic  <= '0;
    end else if (step == '0) begin
      if (go) begin
        step <= step_t'(1);
        vic  <= '0;
      end
    end else if (step == STEP_END) begin
      if (vic == VIC_END) begin
        step <= '0;
        vic  <= '0;
      end else begin
        step <= step_t'(1);
        vic  <= vic + 1'b1;
      end
    end else begin
      step <= step + 1'b1;
    end
  end

  assign last = (step == STEP_END) && (vic == VIC_END);

  p_step_range_r4: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_END);

  p_vic_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (step != '0 && step != STEP_END) |=> ($stable(vic) && step == $past(step) + 1'b1));

  p_first_step_r2: assert property (@(posedge clk) disable iff (rst)
    (step == '0 && go) |=> (step == step_t'(1) && vic == '0));

  p_vic_range_r4: assert property (@(posedge clk) disable iff (rst)
    vic <= VIC_END);

endmodule

// File: rtl/xt_rot.sv
module xt_rot
  import xt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int VW    = $clog2(LANES)
) (
  input  lvl_t             lv,
  input  logic [VW-1:0]    amt,
  output logic [LANES-1:0] word
);

  // Stage s rotates left by 2**s modulo LANES when amt[s] is set.
  logic [LANES-1:0] stg [VW+1];

  assign stg[0] = {{(LANES-1){lv.agg}}, lv.vic};

  for (genvar s = 0; s < VW; s++) begin : g_stage
    localparam int R = (1 << s) % LANES;
    for (genvar i = 0; i < LANES; i++) begin : g_bit
      localparam int SRC = (i + LANES - R) % LANES;
      assign stg[s+1][i] = amt[s] ? stg[s][SRC] : stg[s][i];
    end
  end

  assign word = stg[VW];

endmodule

// File: rtl/xt_cmp.sv
module xt_cmp
  import xt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int VW    = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [LANES-1:0] rx,
  input  logic [LANES-1:0] expw,
  input  logic [VW-1:0]    vic,
  input  step_t            step,
  input  logic             last,
  output logic             err,
  output logic [VW-1:0]    fail_vic,
  output step_t            fail_step,
  output logic             done
);

  logic [LANES-1:0] diff;
  logic             mis;

  assign diff = rx ^ expw;
  assign mis  = en && (|diff);

  always_ff @(posedge clk) begin
    if (rst) begin
      err       <= 1'b0;
      fail_vic  <= '0;
      fail_step <= '0;
      done      <= 1'b0;
    end else if (clr) begin
      err       <= 1'b0;
      fail_vic  <= '0;
      fail_step <= '0;
      done      <= 1'b0;
    end else begin
      done <= last;
      if (mis) begin
        err <= 1'b1;
        if (!err) begin
          fail_vic  <= vic;
          fail_step <= step;
        end
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);

  p_fail_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> ($stable(fail_vic) && $stable(fail_step)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!en && !err && !clr) |=> !err);

  p_mismatch_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (en && rx != expw && !clr) |=> err);

endmodule

// File: rtl/xt_link_bist.sv
module xt_link_bist
  import xt_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int LINK_LAT = 1,
  parameter int VW       = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [LANES-1:0] link_tx,
  input  logic [LANES-1:0] link_rx,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [VW-1:0]    fail_vic,
  output logic [3:0]       fail_step
);

  // Receiver lags by the transmit register plus the link stages.
  localparam int DLY = LINK_LAT + 1;

  logic acc;

  // ---------------- generator end ----------------
  step_t            g_step;
  logic [VW-1:0]    g_vic;
  logic             g_last;
  lvl_t             g_lv;
  logic [LANES-1:0] g_word;

  xt_seq #(.LANES(LANES), .VW(VW)) u_gen_seq (
    .clk (clk), .rst (rst), .go (acc),
    .step(g_step), .vic (g_vic), .last(g_last)
  );

  assign g_lv = step_levels(g_step);

  xt_rot #(.LANES(LANES), .VW(VW)) u_gen_rot (
    .lv(g_lv), .amt(g_vic), .word(g_word)
  );

  always_ff @(posedge clk) begin
    if (rst) link_tx <= '0;
    else     link_tx <= (g_step != '0) ? g_word : '0;
  end

  // ---------------- start delay line ----------------
  logic [DLY-1:0] dly;

  if (DLY == 1) begin : g_dly1
    always_ff @(posedge clk) begin
      if (rst) dly <= '0;
      else     dly <= acc;
    end
  end else begin : g_dlyn
    always_ff @(posedge clk) begin
      if (rst) dly <= '0;
      else     dly <= {dly[DLY-2:0], acc};
    end
  end

  // ---------------- checker end ----------------
  step_t            c_step;
  logic [VW-1:0]    c_vic;
  logic             c_last;
  lvl_t             c_lv;
  logic [LANES-1:0] c_word;

  xt_seq #(.LANES(LANES), .VW(VW)) u_chk_seq (
    .clk (clk), .rst (rst), .go (dly[DLY-1]),
    .step(c_step), .vic (c_vic), .last(c_last)
  );

  assign c_lv = step_levels(c_step);

  xt_rot #(.LANES(LANES), .VW(VW)) u_chk_rot (
    .lv(c_lv), .amt(c_vic), .word(c_word)
  );

  xt_cmp #(.LANES(LANES), .VW(VW)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .clr      (acc),
    .en       (c_step != '0),
    .rx       (link_rx),
    .expw     (c_word),
    .vic      (c_vic),
    .step     (c_step),
    .last     (c_last),
    .err      (err),
    .fail_vic (fail_vic),
    .fail_step(fail_step),
    .done     (done)
  );

  // ---------------- control ----------------
  assign busy = (g_step != '0) || (|dly) || (c_step != '0);
  assign acc  = start && !busy;

  p_victim_level_r3: assert property (@(posedge clk) disable iff (rst)
    (g_step != '0) |-> (g_word[g_vic] == g_lv.vic));

  p_one_victim_r3: assert property (@(posedge clk) disable iff (rst)
    (g_step != '0 && g_lv.vic != g_lv.agg) |->
      ($countones(g_word) == (g_lv.vic ? 1 : LANES - 1)));

  p_busy_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && g_step == '0) |=> (g_step == '0));

  p_lockstep_r5: assert property (@(posedge clk) disable iff (rst)
    (g_step == step_t'(1) && g_vic == '0 && $past(g_step) == '0) |-> busy);

endmodule

// File: tb/tb_xt_link_bist.sv
module tb_xt_link_bist;

  localparam int N   = 8;
  localparam int VW  = 3;
  localparam int TOT = 8 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  link_tx, link_rx, inj = '0;
  logic          busy, done, err;
  logic [VW-1:0] fail_vic;
  logic [3:0]    fail_step;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xt_link_bist #(.LANES(N), .LINK_LAT(1)) dut (
    .clk(clk), .rst(rst), .start(start),
    .link_tx(link_tx), .link_rx(link_rx),
    .busy(busy), .done(done), .err(err),
    .fail_vic(fail_vic), .fail_step(fail_step)
  );

  // One-register link with fault injection.
  always_ff @(posedge clk) begin
    if (rst) link_rx <= '0;
    else     link_rx <= link_tx ^ inj;
  end

  function automatic logic [N-1:0] exp_word(int k);
    int s = k % 8 + 1;
    int v = k / 8;
    logic vb, ab;
    logic [N-1:0] w;
    case (s)
      1, 3:    begin vb = 1'b0; ab = 1'b0; end
      2, 7:    begin vb = 1'b1; ab = 1'b1; end
      4, 6:    begin vb = 1'b0; ab = 1'b1; end
      default: begin vb = 1'b1; ab = 1'b0; end
    endcase
    for (int i = 0; i < N; i++) w[i] = (i == v) ? vb : ab;
    return w;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // One full run. fk/fk2: word indices to corrupt (-1 none); mid: cycle for a
  // stray start pulse (-1 none).
  task automatic run_case(input int fk, input int fk2, input logic [N-1:0] m,
                          input int mid, input int exp_vic, input int exp_step);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check(err == 1'b0, "R8", "err cleared by start", int'(err), 0);
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    for (int j = 1; j <= TOT + 2; j++) begin
      logic [N-1:0] ew;
      logic         ee;
      @(posedge clk);
      @(negedge clk);
      start = (j == mid);
      inj   = ((j - 1) == fk || (j - 1) == fk2) ? m : '0;
      ew    = (j >= 1 && j <= TOT) ? exp_word(j - 1) : '0;
      ee    = (fk >= 0) && (j >= fk + 3);
      check(link_tx == ew, "R3", "link word", int'(link_tx), int'(ew));
      check(done == (j == TOT + 2), "R7", "done timing", int'(done), int'(j == TOT + 2));
      check(busy == (j < TOT + 2), "R9", "busy timing", int'(busy), int'(j < TOT + 2));
      check(err == ee, "R5", "err timing", int'(err), int'(ee));
    end
    @(negedge clk);
    start = 1'b0;
    inj   = '0;
    check(done == 1'b0, "R7", "done single cycle", int'(done), 0);
    check(link_tx == '0, "R4", "link quiet after run", int'(link_tx), 0);
    check(int'(fail_vic) == exp_vic, "R6", "fail_vic", int'(fail_vic), exp_vic);
    check(int'(fail_step) == exp_step, "R6", "fail_step", int'(fail_step), exp_step);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(link_tx == '0 && busy == 0 && done == 0, "R1", "reset outputs", int'(link_tx), 0);
    check(err == 0 && fail_vic == 0 && fail_step == 0, "R1", "reset diag", int'(err), 0);
    rst = 1'b0;

    // R2 R3 R4: clean run
    run_case(-1, -1, '0, -1, 0, 0);
    check(err == 1'b0, "R5", "clean run no error", int'(err), 0);

    // R10: garbage on idle link
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); inj = '1;
    end
    @(negedge clk); inj = '0;
    @(negedge clk);
    check(err == 1'b0, "R10", "idle link ignored", int'(err), 0);

    // R5 R6: first word, victim lane
    run_case(0, -1, 8'h01, -1, 0, 1);
    // R6: two faults, first one kept (victim 3 step 5, then victim 6 step 3)
    run_case(3 * 8 + 4, 6 * 8 + 2, 8'h40, -1, 3, 5);
    // R7: fault on the very last word coincides with done
    run_case(TOT - 1, -1, 8'h80, -1, N - 1, 8);
    // R8: stray start mid-run ignored, and clears previous error at start
    run_case(-1, -1, '0, 20, 0, 0);
    // R8: stray start near the end of the run
    run_case(2 * 8 + 7, -1, 8'h04, TOT, 2, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule